// File: doc/BRIEF.md
# Network Interrupt Cause and Mask Unit

This unit gathers the interrupt sources of a network controller into one 32-bit cause register, gates them with a 32-bit mask and drives a single level interrupt towards the host. Software reaches it through a simple single-cycle register bus. It reads the cause register (which empties it in the same access), forces causes by writing a set port, and grows or shrinks the mask through separate set and clear ports. The transmit engine, receive engine, link monitor and management interface report events as one-cycle pulses. Each pulse lands on a fixed cause bit.

Receive completions are also counted in a small backlog counter. When software reads the cause register while completions are still outstanding, the receive-timer cause comes straight back and the backlog drops by one. A burst of received packets therefore yields one interrupt service pass per packet instead of being folded into a single read. Read data is combinational in the access cycle. All register updates take effect at the clock edge that ends the access.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause register, the mask and the receive backlog are zero and the interrupt output is low.
- R2: A read at offset 0x0C0 returns the cause register as it stood before the access and clears every cause bit at the end of that cycle.
- R3: A write at offset 0x0C8 ORs the write data into the cause register; bits already set stay set.
- R4: A write at offset 0x0D0 ORs the write data into the mask, and a read at offset 0x0D0 returns the mask.
- R5: A write at offset 0x0D8 clears every mask bit that is 1 in the write data and leaves the others unchanged.
- R6: The interrupt output is high exactly when (cause AND mask) is nonzero, and it follows any register change from the cycle after the access.
- R7: Event pulses set fixed cause bits: transmit write-back bit 0, transmit queue empty bit 1, link change bit 2, receive overrun bit 6, receive end-of-packet (receive timer) bit 7, management access done bit 9.
- R8: Each receive end-of-packet pulse increments the receive backlog, which saturates at 2^PEND_W-1 (15 by default).
- R9: A cause read made while the backlog is nonzero leaves bit 7 set after the clear and decrements the backlog by one. With N pending completions and no new events, N+1 consecutive cause reads return bit 7 and the next returns 0.
- R10: A receive end-of-packet pulse in the same cycle as a backlog-decrementing cause read leaves the backlog unchanged.
- R11: Event pulses in the same cycle as a cause read are held in the cause register after the clear, and they appear in the following read.
- R12: Writes to offset 0x0C0 and to unmapped offsets change no state. Reads of 0x0C8, 0x0D8 and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regEn | input | 1 | Register access strobe, one cycle per access |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid in the access cycle |
| evTxWb | input | 1 | Transmit descriptor written back pulse |
| evTxEmpty | input | 1 | Transmit queue empty pulse |
| evLink | input | 1 | Link status change pulse |
| evRxOver | input | 1 | Receive overrun pulse |
| evRxEop | input | 1 | Receive end-of-packet pulse |
| evMdioDone | input | 1 | Management access complete pulse |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench focuses on how the clear interacts with new arrivals. A design that applied the clear after merging events would lose a pulse that lands on the read cycle. A design that re-armed from the backlog after decrementing it would return one read of bit 7 too few. The backlog is drained after bursts of several lengths and after a burst that overruns its saturation point, so off-by-one drain counts and counter wrap show up as a wrong number of bit-7 reads. The simultaneous increment and decrement case is checked by counting reads. A design that let either side win would end one read short or one read long. A sweep of cause and mask patterns compares the interrupt level against the AND computed in the bench, and it also catches a mask clear that touches bits outside its data.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  // Fixed register offsets (software decodes these)
  localparam logic [11:0] OFF_CAUSE = 12'h0C0;
  localparam logic [11:0] OFF_CSET  = 12'h0C8;
  localparam logic [11:0] OFF_MSET  = 12'h0D0;
  localparam logic [11:0] OFF_MCLR  = 12'h0D8;

  // Event input indices
  localparam int EV_N       = 6;
  localparam int EV_TXWB    = 0;
  localparam int EV_TXEMPTY = 1;
  localparam int EV_LINK    = 2;
  localparam int EV_RXOVER  = 3;
  localparam int EV_RXEOP   = 4;
  localparam int EV_MDIO    = 5;

  // Cause bit fed by the receive backlog
  localparam int RXT_BIT = 7;

  // Cause bit position of each event index
  function automatic int evPos(input int idx);
    case (idx)
      EV_TXWB:    return 0;
      EV_TXEMPTY: return 1;
      EV_LINK:    return 2;
      EV_RXOVER:  return 6;
      EV_RXEOP:   return RXT_BIT;
      default:    return 9;
    endcase
  endfunction

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic rdCause;
    logic setCause;
    logic rdMask;
    logic setMask;
    logic clrMask;
  } regStb_t;

endpackage

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              regEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStb_t           stb
);

  logic hitCause, hitCset, hitMset, hitMclr;

  always_comb begin
    hitCause = (regAddr == ADDR_W'(OFF_CAUSE));
    hitCset  = (regAddr == ADDR_W'(OFF_CSET));
    hitMset  = (regAddr == ADDR_W'(OFF_MSET));
    hitMclr  = (regAddr == ADDR_W'(OFF_MCLR));
  end

  always_comb begin
    stb.rdCause  = regEn && !regWr && hitCause;
    stb.setCause = regEn &&  regWr && hitCset;
    stb.rdMask   = regEn && !regWr && hitMset;
    stb.setMask  = regEn &&  regWr && hitMset;
    stb.clrMask  = regEn &&  regWr && hitMclr;
  end

endmodule

// File: rtl/irq_cause_dp.sv
module irq_cause_dp
  import irq_cause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [EV_N-1:0]   evIn,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] causeQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [PEND_W-1:0] pendQ
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [DATA_W-1:0] evBits;
  logic [DATA_W-1:0] causeD, maskD;
  logic [PEND_W-1:0] pendD;
  logic              pendInc, pendDec;

  // Map event pulses to their cause bits
  always_comb begin
    evBits = '0;
    for (int i = 0; i < EV_N; i++) begin
      evBits[evPos(i)] = evBits[evPos(i)] | evIn[i];
    end
  end

  always_comb begin
    pendInc = evIn[EV_RXEOP];
    pendDec = stb.rdCause && (pendQ != '0);
  end

  // Clear first, then merge arrivals so same-cycle events survive
  always_comb begin
    causeD = causeQ;
    if (stb.rdCause) causeD = '0;
    causeD = causeD | evBits;
    if (stb.setCause) causeD = causeD | regWdata;
    if (pendDec) causeD[RXT_BIT] = 1'b1;
  end

  always_comb begin
    maskD = maskQ;
    if (stb.setMask) maskD = maskD | regWdata;
    if (stb.clrMask) maskD = maskD & ~regWdata;
  end

  always_comb begin
    pendD = pendQ;
    if (pendInc && !pendDec && (pendQ != PEND_MAX)) pendD = pendQ + 1'b1;
    else if (pendDec && !pendInc)                   pendD = pendQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
      pendQ  <= '0;
    end else begin
      causeQ <= causeD;
      maskQ  <= maskD;
      pendQ  <= pendD;
    end
  end

  always_comb begin
    regRdata = '0;
    if (stb.rdCause)     regRdata = causeQ;
    else if (stb.rdMask) regRdata = maskQ;
  end

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evTxWb,
  input  logic              evTxEmpty,
  input  logic              evLink,
  input  logic              evRxOver,
  input  logic              evRxEop,
  input  logic              evMdioDone,
  output logic              irqOut
);

  regStb_t           stb;
  logic [EV_N-1:0]   evIn;
  logic [DATA_W-1:0] causeQ, maskQ;
  logic [PEND_W-1:0] pendQ;

  always_comb begin
    evIn             = '0;
    evIn[EV_TXWB]    = evTxWb;
    evIn[EV_TXEMPTY] = evTxEmpty;
    evIn[EV_LINK]    = evLink;
    evIn[EV_RXOVER]  = evRxOver;
    evIn[EV_RXEOP]   = evRxEop;
    evIn[EV_MDIO]    = evMdioDone;
  end

  irq_cause_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regEn   (regEn),
    .regWr   (regWr),
    .regAddr (regAddr),
    .stb     (stb)
  );

  irq_cause_dp #(.DATA_W(DATA_W), .PEND_W(PEND_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWdata (regWdata),
    .evIn     (evIn),
    .regRdata (regRdata),
    .causeQ   (causeQ),
    .maskQ    (maskQ),
    .pendQ    (pendQ)
  );

  assign irqOut = |(causeQ & maskQ);

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
  import irq_cause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input regStb_t           stb,
  input logic [DATA_W-1:0] regWdata,
  input logic              evTxWb,
  input logic              evRxEop,
  input logic              irqOut,
  input logic [DATA_W-1:0] causeQ,
  input logic [DATA_W-1:0] maskQ,
  input logic [PEND_W-1:0] pendQ
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (causeQ == '0 && maskQ == '0 && pendQ == '0 && !irqOut));

  // R5
  full_mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask && regWdata == '1 && !stb.setMask) |=> (maskQ == '0 && !irqOut));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask && !stb.clrMask) |=> ((maskQ & $past(regWdata)) == $past(regWdata)));

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdCause && pendQ != '0) |=> causeQ[RXT_BIT]);

  // R10
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdCause && pendQ != '0 && evRxEop) |=> $stable(pendQ));

  // R11
  event_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    evTxWb |=> causeQ[0]);

  // R3
  cause_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setCause |=> ((causeQ & $past(regWdata)) == $past(regWdata)));

endmodule

bind irq_cause_unit irq_cause_chk #(.DATA_W(DATA_W), .PEND_W(PEND_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stb      (stb),
  .regWdata (regWdata),
  .evTxWb   (evTxWb),
  .evRxEop  (evRxEop),
  .irqOut   (irqOut),
  .causeQ   (causeQ),
  .maskQ    (maskQ),
  .pendQ    (pendQ)
);

// File: tb/irq_cause_unit_bench.sv
module irq_cause_unit_bench;

  localparam logic [11:0] A_CAUSE = 12'h0C0;
  localparam logic [11:0] A_CSET  = 12'h0C8;
  localparam logic [11:0] A_MSET  = 12'h0D0;
  localparam logic [11:0] A_MCLR  = 12'h0D8;
  localparam logic [11:0] A_OTHER = 12'h0C4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0, regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [5:0]  ev = '0;
  logic        irqOut;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  irq_cause_unit u_irq_cause_unit (
    .clk(clk), .rstN(rstN),
    .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .evTxWb(ev[0]), .evTxEmpty(ev[1]), .evLink(ev[2]),
    .evRxOver(ev[3]), .evRxEop(ev[4]), .evMdioDone(ev[5]),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle with optional event pulses; rd captured in the access cycle
  task automatic busOp(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [5:0] evv, output logic [31:0] rd);
    @(negedge clk);
    regEn = 1'b1; regWr = wr; regAddr = a; regWdata = d; ev = evv;
    #1 rd = regRdata;
    @(posedge clk);
    #1 regEn = 1'b0; regWr = 1'b0; ev = '0;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    busOp(1'b1, a, d, 6'b0, dummy);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] rd);
    busOp(1'b0, a, 32'h0, 6'b0, rd);
  endtask

  task automatic pulse(input logic [5:0] evv);
    @(negedge clk); ev = evv;
    @(posedge clk); #1 ev = '0;
  endtask

  // Expect n reads returning bit 7, then one returning 0
  task automatic drain(input string req, input int n);
    logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      rd32(A_CAUSE, r);
      check(req, r, 32'h80);
    end
    rd32(A_CAUSE, r);
    check(req, r, 32'h0);
  endtask

  function automatic logic [31:0] evBit(input int i);
    case (i)
      0: return 32'h001;
      1: return 32'h002;
      2: return 32'h004;
      3: return 32'h040;
      4: return 32'h080;
      default: return 32'h200;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, acc;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    rd32(A_CAUSE, r); check("R1 cause", r, 32'h0);
    rd32(A_MSET, r);  check("R1 mask", r, 32'h0);

    // R4 mask set, per bit accumulation
    acc = '0;
    for (int b = 0; b < 32; b++) begin
      wr32(A_MSET, 32'h1 << b);
      acc = acc | (32'h1 << b);
      rd32(A_MSET, r); check("R4 mask set", r, acc);
    end
    // R5 mask clear, per bit
    for (int b = 31; b >= 0; b--) begin
      wr32(A_MCLR, 32'h1 << b);
      acc = acc & ~(32'h1 << b);
      rd32(A_MSET, r); check("R5 mask clear", r, acc);
    end

    // R3 R2 cause set ORs, read returns then clears
    wr32(A_CSET, 32'h0000_F00F);
    wr32(A_CSET, 32'h00F0_0000);
    rd32(A_CAUSE, r); check("R3 cause or", r, 32'h00F0_F00F);
    rd32(A_CAUSE, r); check("R2 clear on read", r, 32'h0);

    // R6 interrupt level sweep
    for (int t = 0; t < 64; t++) begin
      logic [31:0] cp, mp;
      cp = {t[5:0], 10'h0, t[5:0] ^ 6'h2A, 4'h0, t[5:0]};
      mp = 32'hFFFF_FFFF >> (t % 33);
      mp = mp ^ {t[3:0], 28'h0};
      wr32(A_MCLR, 32'hFFFF_FFFF);
      wr32(A_MSET, mp);
      wr32(A_CSET, cp);
      check("R6 irq level", {31'b0, irqOut}, {31'b0, |(cp & mp)});
      rd32(A_CAUSE, r); check("R2 read value", r, cp);
      check("R6 irq after clear", {31'b0, irqOut}, 32'h0);
    end
    wr32(A_MCLR, 32'hFFFF_FFFF);

    // R7 event mapping
    for (int i = 0; i < 6; i++) begin
      pulse(6'b1 << i);
      rd32(A_CAUSE, r); check("R7 event bit", r, evBit(i));
      if (i == 4) drain("R9 single", 1);
      else begin rd32(A_CAUSE, r); check("R7 event cleared", r, 32'h0); end
    end

    // R8 R9 bursts of several lengths
    for (int n = 1; n <= 5; n++) begin
      for (int k = 0; k < n; k++) pulse(6'b010000);
      drain("R9 backlog drain", n + 1);
    end

    // R8 saturation at 15
    for (int k = 0; k < 20; k++) pulse(6'b010000);
    drain("R8 saturate", 16);

    // R10 increment and decrement cancel
    pulse(6'b010000); pulse(6'b010000);
    busOp(1'b0, A_CAUSE, 32'h0, 6'b010000, r);
    check("R10 read value", r, 32'h80);
    drain("R10 backlog held", 3);

    // R11 event on read cycle kept
    busOp(1'b0, A_CAUSE, 32'h0, 6'b000001, r);
    check("R11 read old", r, 32'h0);
    rd32(A_CAUSE, r); check("R11 event kept", r, 32'h1);
    wr32(A_CSET, 32'h4);
    busOp(1'b0, A_CAUSE, 32'h0, 6'b100000, r);
    check("R11 read old set", r, 32'h4);
    rd32(A_CAUSE, r); check("R11 mdio kept", r, 32'h200);

    // R12 ignored writes and zero reads
    wr32(A_CAUSE, 32'hFFFF_FFFF);
    wr32(A_OTHER, 32'hFFFF_FFFF);
    rd32(A_CAUSE, r); check("R12 cause untouched", r, 32'h0);
    rd32(A_MSET, r);  check("R12 mask untouched", r, 32'h0);
    wr32(A_MSET, 32'h0000_000F);
    wr32(A_CSET, 32'h0000_0003);
    rd32(A_MCLR, r);  check("R12 mclr reads zero", r, 32'h0);
    rd32(A_CSET, r);  check("R12 cset reads zero", r, 32'h0);
    rd32(A_OTHER, r); check("R12 other reads zero", r, 32'h0);
    check("R6 irq still set", {31'b0, irqOut}, 32'h1);
    rd32(A_CAUSE, r); check("R12 cause kept", r, 32'h3);
    rd32(A_MSET, r);  check("R12 mask kept", r, 32'hF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule